// File: doc/BRIEF.md
# Next-Address Sequencer for a Fixed-Width Instruction Stream

This block owns the program counter of a simple 32-bit core. In each cycle it looks at the fetched instruction word and the two register operand values read for it. From these it works out the address of the following instruction. Straight-line code steps forward by one 4-byte instruction. Two compare-and-branch instructions redirect by a signed count of instructions. Two long jumps take a word-aligned absolute field. A register jump goes to any 32-bit address held in a source register.

The next address and a redirect flag are available in the same cycle. They feed the PC register, which loads on each enabled clock edge and returns to a parameterised start address on reset. The jump-and-link form also returns a link request: on the cycle after it is accepted, the block presents the return address (its own address plus 4) and a one-cycle write strobe aimed at the return-address register, ready for the register file's write port.

Top module: `flow_pc_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `pc` takes the value of parameter RESET_PC (default 0x0040_0000) and `link_we` goes to 0.
- R2: An opcode (bits 31:26) that is none of 0x02, 0x03, 0x04, 0x05, and opcode 0x00 with a function field (bits 5:0) other than 0x08, gives `next_pc` = `pc` + 4 and `taken` = 0.
- R3: Opcode 0x04 (branch if equal) with `rs_val` == `rt_val` gives `taken` = 1 and `next_pc` = `pc` + 4 + (sign-extended bits 15:0 multiplied by 4). With unequal operands it gives `pc` + 4 and `taken` = 0.
- R4: Opcode 0x05 (branch if not equal) is taken only when `rs_val` != `rt_val`, with the same target as R3. With equal operands it gives `pc` + 4 and `taken` = 0.
- R5: A branch offset with bit 15 set moves the target backwards. For example, 0xFFFE from `pc` 0x1000 gives 0x0FFC.
- R6: Opcode 0x02 gives `taken` = 1 and `next_pc` = {(`pc`+4)[31:28], bits 25:0, 2'b00}. The upper nibble comes from `pc` + 4, not from `pc`.
- R7: Opcode 0x03 redirects as in R6. After the edge that accepts it, `link_we` is 1 for exactly one cycle with `link_val` = its `pc` + 4. `link_addr` is always 31.
- R8: Opcode 0x00 with function 0x08 gives `taken` = 1 and `next_pc` = `rs_val`, with all 32 bits used unchanged.
- R9: On an edge where `en` is 0, `pc` keeps its value and `link_we` becomes 0, even if the instruction is opcode 0x03.
- R10: On an edge where `en` is 1 and `rst` is 0, `pc` loads the `next_pc` value presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable for the PC and link registers |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | output | 32 | Current program counter (registered) |
| next_pc | output | 32 | Address the PC loads on the next enabled edge |
| taken | output | 1 | Redirect away from sequential flow |
| link_we | output | 1 | One-cycle write request for the return address |
| link_addr | output | 5 | Destination register index of the link write |
| link_val | output | 32 | Return address to be written |

## Verification
A jump-and-link is followed at once by a register jump. In the second cycle, the delayed link request from the first instruction is on the outputs while the redirect of the second is being computed. The bench checks, before that edge, that `link_we` and `link_val` still describe the earlier instruction and that `next_pc` already equals the register target. After the edge it checks that the strobe has dropped. A long jump placed in the last word of a 256 MB region covers a second overlap: the incremented PC and the jump target are formed together, and the target must take its upper nibble from the incremented value.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_JAL,
    FLOW_JREG
  } flow_e;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JMP     = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] FN_JREG    = 6'h08;

  localparam int unsigned OP_W   = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JFLD_W = 26;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [5:0]      func,
  output flow_e           flow
);
  always_comb begin
    unique case (opcode)
      OP_BEQ:     flow = FLOW_BEQ;
      OP_BNE:     flow = FLOW_BNE;
      OP_JMP:     flow = FLOW_JMP;
      OP_JAL:     flow = FLOW_JAL;
      OP_SPECIAL: flow = (func == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
      default:    flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JFLD_W-1:0] jfield,
  output logic [XLEN-1:0]   seq_tgt,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   jmp_tgt
);
  localparam int unsigned STEP   = 1 << ALIGN_BITS;
  localparam int unsigned EXT_W  = XLEN - IMM_W - ALIGN_BITS;
  localparam int unsigned REGION = XLEN - JFLD_W - ALIGN_BITS;

  logic [XLEN-1:0] offset;

  assign seq_tgt = pc + XLEN'(STEP);
  assign offset  = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_BITS{1'b0}}};
  assign br_tgt  = seq_tgt + offset;

  generate
    if (REGION > 0) begin : g_region
      assign jmp_tgt = {seq_tgt[XLEN-1 -: REGION], jfield, {ALIGN_BITS{1'b0}}};
    end else begin : g_flat
      assign jmp_tgt = {jfield, {ALIGN_BITS{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_e           flow,
  input  logic            ops_equal,
  input  logic [XLEN-1:0] seq_tgt,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] target,
  output logic            redirect,
  output logic            is_link
);
  always_comb begin
    redirect = 1'b0;
    target   = seq_tgt;
    is_link  = 1'b0;
    unique case (flow)
      FLOW_BEQ: if (ops_equal) begin
        redirect = 1'b1;
        target   = br_tgt;
      end
      FLOW_BNE: if (!ops_equal) begin
        redirect = 1'b1;
        target   = br_tgt;
      end
      FLOW_JMP: begin
        redirect = 1'b1;
        target   = jmp_tgt;
      end
      FLOW_JAL: begin
        redirect = 1'b1;
        target   = jmp_tgt;
        is_link  = 1'b1;
      end
      FLOW_JREG: begin
        redirect = 1'b1;
        target   = reg_tgt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     REG_AW   = 5,
  parameter int unsigned     LINK_REG = 31,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [REG_AW-1:0] link_addr,
  output logic [XLEN-1:0]   link_val
);
  flow_e           flow;
  logic [XLEN-1:0] seq_tgt;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic            is_link;

  npc_decode u_decode (
    .opcode (instr[31:26]),
    .func   (instr[5:0]),
    .flow   (flow)
  );

  npc_targets #(.XLEN(XLEN)) u_targets (
    .pc      (pc),
    .imm     (instr[15:0]),
    .jfield  (instr[25:0]),
    .seq_tgt (seq_tgt),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .flow      (flow),
    .ops_equal (rs_val == rt_val),
    .seq_tgt   (seq_tgt),
    .br_tgt    (br_tgt),
    .jmp_tgt   (jmp_tgt),
    .reg_tgt   (rs_val),
    .target    (next_pc),
    .redirect  (taken),
    .is_link   (is_link)
  );

  assign link_addr = REG_AW'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_PC;
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      link_we <= en && is_link;
      if (en) begin
        pc <= next_pc;
        if (is_link) link_val <= seq_tgt;
      end
    end
  end
endmodule

// File: rtl/flow_pc_unit_chk.sv
module flow_pc_unit_chk #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [5:0]      opcode,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [XLEN-1:0] link_val
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) $past(rst) |-> (pc == RESET_PC && !link_we));

  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> pc == $past(next_pc));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!en) && !$past(rst)) |-> ($stable(pc) && !link_we));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |-> next_pc == pc + XLEN'(4));

  // R4
  bne_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'h05 && rs_val == rt_val) |-> !taken);

  // R6
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'h02) |-> (taken && next_pc[1:0] == 2'b00));

  // R7
  link_src_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> ($past(en) && $past(opcode) == 6'h03 && link_val == $past(pc) + XLEN'(4)));

  // R7
  link_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (link_we && opcode != 6'h03) |=> !link_we);
endmodule

bind flow_pc_unit flow_pc_unit_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .opcode   (instr[31:26]),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .pc       (pc),
  .next_pc  (next_pc),
  .taken    (taken),
  .link_we  (link_we),
  .link_val (link_val)
);

// File: tb/test_flow_pc_unit.sv
`timescale 1ns/1ps
module test_flow_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc, next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flow_pc_unit i_flow_pc_unit (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_addr(link_addr), .link_val(link_val)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd8, 5'd9, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction
  localparam logic [31:0] JR_W  = {6'h00, 5'd31, 15'd0, 6'h08};
  localparam logic [31:0] ADD_W = {6'h00, 5'd8, 5'd9, 5'd10, 5'd0, 6'h20};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic set_pc(input logic [31:0] v);
    @(negedge clk);
    en = 1'b1; instr = JR_W; rs_val = v; rt_val = '0;
    @(posedge clk); #1;
  endtask

  // drive one instruction, check the combinational result, then the loaded PC
  task automatic step(input string req, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] exp_np, input logic exp_tk);
    @(negedge clk);
    en = 1'b1; instr = w; rs_val = a; rt_val = b;
    #1;
    chk(req, next_pc, exp_np);
    chk(req, {31'd0, taken}, {31'd0, exp_tk});
    @(posedge clk); #1;
    chk({req, " pc load R10"}, pc, exp_np);
  endtask

  task automatic t_reset();
    // R1
    chk("R1 pc", pc, 32'h0040_0000);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);
    chk("R7 link_addr", {27'd0, link_addr}, 32'd31);
  endtask

  task automatic t_sequential();
    set_pc(32'h0000_1000);
    step("R2 add", ADD_W, 32'd1, 32'd1, 32'h0000_1004, 1'b0);
    step("R2 other op", enc_i(6'h08, 16'h0010), 32'd0, 32'd0, 32'h0000_1008, 1'b0);
  endtask

  task automatic t_branches();
    set_pc(32'h0000_1000);
    step("R3 beq taken", enc_i(6'h04, 16'h0003), 32'd7, 32'd7, 32'h0000_1010, 1'b1);
    set_pc(32'h0000_1000);
    step("R3 beq not taken", enc_i(6'h04, 16'h0003), 32'd7, 32'd8, 32'h0000_1004, 1'b0);
    set_pc(32'h0000_1000);
    step("R4 R5 bne back", enc_i(6'h05, 16'hFFFE), 32'd1, 32'd2, 32'h0000_0FFC, 1'b1);
    set_pc(32'h0000_1000);
    step("R4 bne equal", enc_i(6'h05, 16'hFFFE), 32'd5, 32'd5, 32'h0000_1004, 1'b0);
  endtask

  task automatic t_jumps();
    set_pc(32'h0FFF_FFFC);
    step("R6 j region", enc_j(6'h02, 26'h000_0010), 32'd0, 32'd0, 32'h1000_0040, 1'b1);
    set_pc(32'h0000_3000);
    step("R8 jr", JR_W, 32'hDEAD_BEEC, 32'd0, 32'hDEAD_BEEC, 1'b1);
  endtask

  task automatic t_link_overlap();
    set_pc(32'h0000_2000);
    step("R7 jal", enc_j(6'h03, 26'h000_0100), 32'd0, 32'd0, 32'h0000_0400, 1'b1);
    chk("R7 link_we", {31'd0, link_we}, 32'd1);
    chk("R7 link_val", link_val, 32'h0000_2004);
    @(negedge clk);
    instr = JR_W; rs_val = 32'h0000_2004; en = 1'b1;
    #1;
    chk("R7 link held", {31'd0, link_we}, 32'd1);
    chk("R8 jr overlap", next_pc, 32'h0000_2004);
    @(posedge clk); #1;
    chk("R7 one pulse", {31'd0, link_we}, 32'd0);
    chk("R10 pc", pc, 32'h0000_2004);
  endtask

  task automatic t_enable_low();
    set_pc(32'h0000_5000);
    @(negedge clk);
    en = 1'b0; instr = enc_j(6'h03, 26'h000_0200);
    @(posedge clk); #1;
    chk("R9 pc hold", pc, 32'h0000_5000);
    chk("R9 no link", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    en = 1'b1; instr = ADD_W;
    @(posedge clk); #1;
    chk("R9 resume", pc, 32'h0000_5004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_sequential();
    t_branches();
    t_jumps();
    t_link_overlap();
    t_enable_low();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 re-reset", pc, 32'h0040_0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule